// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block ends a transfer for an I2C master. Software writes a one-shot stop request. The block keeps it as a pending trigger bit until a legal wait point arrives on the bus. It then drives SDA low and releases SCL. It waits for SCL to be seen high, which allows a slave to stretch the clock. After SCL has been high for a setup count, it releases SDA so that SDA rises while SCL is high.

A two-flop synchronised detector watches the bus for a rising SDA edge while SCL is high. The detector sets a sticky stop-detected flag and clears the trigger automatically. The trigger is also cleared by lost arbitration, by a release-from-communication command and by disabling the block. Byte shifting lives elsewhere. A byte engine reports wait periods and whether the current wait follows the 8th or the 9th clock. A wait-point select decides which of those waits may launch a stop. When the stop launches from the 8th-clock wait, the SCL release of the stop sequence is the high phase of the 9th clock.

Both line outputs are open-drain pull enables: 1 pulls the line low and 0 releases it.

Top module: `i2c_stop_seq`

## Requirements
- R1: In master transmit mode with the block enabled, a write with the stop bit set and the start bit clear sets `stop_pend` at the clock edge that samples the write.
- R2: A stop write while `master_mode` is 0 leaves `stop_pend` at 0.
- R3: A write that sets the stop bit and the start bit together is rejected and leaves `stop_pend` unchanged.
- R4: A further stop write while `stop_pend` is 1 has no effect. The running sequence is not restarted, and exactly one stop appears on the bus.
- R5: In master receive mode (`rx_mode`=1), a stop write is accepted only while `wait_now`=1 and `ack_en`=0. Any other stop write is ignored.
- R6: A pending stop launches (`stop_active` rises) only during a wait whose `wait_after9` equals `wait_sel`. With `wait_sel`=0 that is the wait after the 8th clock; with 1 it is the wait after the 9th clock.
- R7: On launch, both `sda_pull` and `scl_pull` are 1 for T_LOW_CYC cycles. Then SCL is released while SDA stays pulled low for as long as SCL is held low externally (stretching).
- R8: SDA is released only after SCL has been sampled high on T_SU_CYC consecutive synchronised cycles. A low sample restarts the count.
- R9: A rising SDA edge while SCL is high on the bus sets `stop_det` three clock edges after the bus change. The flag clears on any write that carries the start or stop bit, and when the block is disabled.
- R10: `stop_pend` clears on the edge that sees `arb_lost`, a write with `wr_release`, `enable`=0, or a detected bus stop. The clear has priority over a stop write in the same cycle, and any running sequence returns to idle with both lines released.
- R11: After reset, `stop_pend`, `stop_active` and `stop_det` are 0 and both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 clears trigger and flag |
| master_mode | input | 1 | Block currently acts as bus master |
| rx_mode | input | 1 | 1 = master receive, 0 = master transmit |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| wr_en | input | 1 | Control register write strobe |
| wr_stop | input | 1 | Stop trigger bit of the written value |
| wr_start | input | 1 | Start trigger bit of the written value |
| wr_release | input | 1 | Release-from-communication bit of the written value |
| arb_lost | input | 1 | Arbitration loss pulse |
| wait_sel | input | 1 | Wait point: 0 after 8th clock, 1 after 9th clock |
| wait_now | input | 1 | Byte engine is holding a wait period |
| wait_after9 | input | 1 | Current wait follows the 9th clock |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| stop_pend | output | 1 | Stop trigger pending |
| stop_active | output | 1 | Stop sequence in progress |
| stop_det | output | 1 | Sticky stop-detected flag |

## Verification
Assertions in the RTL guard the invariants on every cycle. SCL is never pulled without SDA. Entry into setup and the release of SDA both follow a synchronised high SCL sample. A rejected or non-master write leaves the trigger clear. Arbitration loss and disable drop the trigger on the next edge. A detected stop raises the flag. The bench's cycle model of the trigger and flag, driven from the bus it builds with pull-ups and a stretching slave, covers what only scenarios show: launch gated by the wait-point select, the hold through a long stretch, the single stop under a repeated write, the setup length before SDA rises, and the clears from the release command and from external stops.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SDA_LOW = 3'd1,
        ST_SCL_REL = 3'd2,
        ST_SETUP   = 3'd3,
        ST_SDA_REL = 3'd4
    } stop_state_e;

endpackage

// File: rtl/i2c_stop_detect.sv
module i2c_stop_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic stop_pulse
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   sda_p;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d        = det_q;
        det_d.scl_sh = {det_q.scl_sh[SYNC_STAGES-2:0], scl_in};
        det_d.sda_sh = {det_q.sda_sh[SYNC_STAGES-2:0], sda_in};
        det_d.sda_p  = det_q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '1;
        else        det_q <= det_d;
    end

    assign scl_s      = det_q.scl_sh[SYNC_STAGES-1];
    assign stop_pulse = scl_s && det_q.sda_sh[SYNC_STAGES-1] && !det_q.sda_p;

endmodule

// File: rtl/i2c_stop_trigger.sv
module i2c_stop_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic master_mode,
    input  logic rx_mode,
    input  logic ack_en,
    input  logic wr_en,
    input  logic wr_stop,
    input  logic wr_start,
    input  logic wr_release,
    input  logic arb_lost,
    input  logic wait_now,
    input  logic stop_pulse,
    output logic stop_pend,
    output logic stop_det
);
    typedef struct packed {
        logic pend;
        logic det;
    } trig_t;

    trig_t trig_d, trig_q;
    logic  accept, clear_ev, rx_ok;

    always_comb begin
        rx_ok    = !rx_mode || (wait_now && !ack_en);
        accept   = wr_en && wr_stop && !wr_start && master_mode && enable && rx_ok;
        clear_ev = !enable || arb_lost || stop_pulse || (wr_en && wr_release);
        trig_d   = trig_q;
        if (clear_ev)    trig_d.pend = 1'b0;
        else if (accept) trig_d.pend = 1'b1;
        if (!enable)                              trig_d.det = 1'b0;
        else if (stop_pulse)                      trig_d.det = 1'b1;
        else if (wr_en && (wr_stop || wr_start))  trig_d.det = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig_d;
    end

    assign stop_pend = trig_q.pend;
    assign stop_det  = trig_q.det;

    // R3: stop together with start is rejected
    a_r3_no_stop_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_stop && wr_start && !stop_pend) |=> !stop_pend);
    // R2: writes outside master mode are ignored
    a_r2_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !master_mode && !stop_pend) |=> !stop_pend);
    // R10: arbitration loss and disable drop the trigger
    a_r10_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost || !enable) |=> !stop_pend);
    // R9: a detected stop raises the flag
    a_r9_det_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse && enable) |=> stop_det);

endmodule

// File: rtl/i2c_stop_timer.sv
module i2c_stop_timer
    import i2c_stop_pkg::*;
#(
    parameter int T_LOW_CYC = 4,
    parameter int T_SU_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_pend,
    input  logic wait_now,
    input  logic wait_after9,
    input  logic wait_sel,
    input  logic scl_s,
    output logic scl_pull,
    output logic sda_pull,
    output logic stop_active
);
    localparam int MAX_CYC = (T_LOW_CYC > T_SU_CYC) ? T_LOW_CYC : T_SU_CYC;
    localparam int CW      = $clog2(MAX_CYC) + 1;

    typedef struct packed {
        stop_state_e   st;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic wait_ok;

    always_comb begin
        wait_ok = wait_now && (wait_after9 == wait_sel);
        tmr_d   = tmr_q;
        if (!stop_pend) begin
            tmr_d.st  = ST_IDLE;
            tmr_d.cnt = '0;
        end else begin
            case (tmr_q.st)
                ST_IDLE: begin
                    if (wait_ok) begin
                        tmr_d.st  = ST_SDA_LOW;
                        tmr_d.cnt = '0;
                    end
                end
                ST_SDA_LOW: begin
                    if (tmr_q.cnt == CW'(T_LOW_CYC - 1)) begin
                        tmr_d.st  = ST_SCL_REL;
                        tmr_d.cnt = '0;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + 1'b1;
                    end
                end
                ST_SCL_REL: begin
                    if (scl_s) begin
                        tmr_d.st  = ST_SETUP;
                        tmr_d.cnt = '0;
                    end
                end
                ST_SETUP: begin
                    if (!scl_s) begin
                        tmr_d.st  = ST_SCL_REL;
                        tmr_d.cnt = '0;
                    end else if (tmr_q.cnt == CW'(T_SU_CYC - 1)) begin
                        tmr_d.st = ST_SDA_REL;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + 1'b1;
                    end
                end
                ST_SDA_REL: tmr_d = tmr_q;
                default: begin
                    tmr_d.st  = ST_IDLE;
                    tmr_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.st  <= ST_IDLE;
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign sda_pull    = (tmr_q.st == ST_SDA_LOW) || (tmr_q.st == ST_SCL_REL) || (tmr_q.st == ST_SETUP);
    assign scl_pull    = (tmr_q.st == ST_SDA_LOW);
    assign stop_active = (tmr_q.st != ST_IDLE);

    // R7: SCL is only pulled while SDA is also pulled
    a_r7_scl_needs_sda: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> sda_pull);
    // R7: setup starts only after a high SCL sample
    a_r7_setup_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.st == ST_SETUP && $past(tmr_q.st) == ST_SCL_REL) |-> $past(scl_s));
    // R8: SDA released only from a high SCL sample
    a_r8_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.st == ST_SDA_REL && $past(tmr_q.st) == ST_SETUP) |-> $past(scl_s));

endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq #(
    parameter int T_LOW_CYC   = 4,
    parameter int T_SU_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic master_mode,
    input  logic rx_mode,
    input  logic ack_en,
    input  logic wr_en,
    input  logic wr_stop,
    input  logic wr_start,
    input  logic wr_release,
    input  logic arb_lost,
    input  logic wait_sel,
    input  logic wait_now,
    input  logic wait_after9,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_pull,
    output logic sda_pull,
    output logic stop_pend,
    output logic stop_active,
    output logic stop_det
);
    logic scl_s, stop_pulse;

    i2c_stop_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_s      (scl_s),
        .stop_pulse (stop_pulse)
    );

    i2c_stop_trigger u_trigger (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .master_mode (master_mode),
        .rx_mode     (rx_mode),
        .ack_en      (ack_en),
        .wr_en       (wr_en),
        .wr_stop     (wr_stop),
        .wr_start    (wr_start),
        .wr_release  (wr_release),
        .arb_lost    (arb_lost),
        .wait_now    (wait_now),
        .stop_pulse  (stop_pulse),
        .stop_pend   (stop_pend),
        .stop_det    (stop_det)
    );

    i2c_stop_timer #(.T_LOW_CYC(T_LOW_CYC), .T_SU_CYC(T_SU_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_pend   (stop_pend),
        .wait_now    (wait_now),
        .wait_after9 (wait_after9),
        .wait_sel    (wait_sel),
        .scl_s       (scl_s),
        .scl_pull    (scl_pull),
        .sda_pull    (sda_pull),
        .stop_active (stop_active)
    );

endmodule

// File: tb/i2c_stop_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_stop_seq_tb_top;
    localparam int T_LOW = 4;
    localparam int T_SU  = 4;

    logic clk = 0, rst_n = 0;
    logic enable = 1, master_mode = 1, rx_mode = 0, ack_en = 1;
    logic wr_en = 0, wr_stop = 0, wr_start = 0, wr_release = 0, arb_lost = 0;
    logic wait_sel = 1, wait_now = 0, wait_after9 = 0;
    logic eng_hold = 0, stretch = 0, ext_sda = 0;
    logic scl_pull, sda_pull, stop_pend, stop_active, stop_det;
    logic scl_bus, sda_bus;

    int checks = 0, errors = 0, stops = 0, last_run = 0, run = 0;
    logic r_pend = 0, r_det = 0, sda_prev = 1;
    logic hs[$], hd[$];

    always #2.5 clk = ~clk;

    assign scl_bus = !(scl_pull === 1'b1 || eng_hold || stretch);
    assign sda_bus = !(sda_pull === 1'b1 || ext_sda);

    i2c_stop_seq #(.T_LOW_CYC(T_LOW), .T_SU_CYC(T_SU)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
        .rx_mode(rx_mode), .ack_en(ack_en), .wr_en(wr_en), .wr_stop(wr_stop),
        .wr_start(wr_start), .wr_release(wr_release), .arb_lost(arb_lost),
        .wait_sel(wait_sel), .wait_now(wait_now), .wait_after9(wait_after9),
        .scl_in(scl_bus), .sda_in(sda_bus), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .stop_pend(stop_pend), .stop_active(stop_active), .stop_det(stop_det)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of trigger and flag, run away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            r_pend = 0; r_det = 0; run = 0; sda_prev = 1;
            hs = '{1'b1, 1'b1, 1'b1, 1'b1};
            hd = '{1'b1, 1'b1, 1'b1, 1'b1};
        end else begin
            logic pulse, acc, clr;
            int n;
            check(stop_pend === r_pend, "R1,R10 model pending", int'(stop_pend), int'(r_pend));
            check(stop_det === r_det, "R9 model stop_det", int'(stop_det), int'(r_det));
            hs.push_back(scl_bus);
            hd.push_back(sda_bus);
            n = hs.size();
            pulse = (hs[n-3] === 1'b1) && (hd[n-3] === 1'b1) && (hd[n-4] === 1'b0);
            acc = wr_en && wr_stop && !wr_start && master_mode && enable &&
                  (!rx_mode || (wait_now && !ack_en));
            clr = !enable || arb_lost || pulse || (wr_en && wr_release);
            if (clr) r_pend = 0; else if (acc) r_pend = 1;
            if (!enable) r_det = 0;
            else if (pulse) r_det = 1;
            else if (wr_en && (wr_stop || wr_start)) r_det = 0;
            if (scl_bus) run++; else run = 0;
            if (scl_bus && sda_bus && !sda_prev) begin stops++; last_run = run; end
            sda_prev = sda_bus;
            while (hs.size() > 8) begin void'(hs.pop_front()); void'(hd.pop_front()); end
        end
    end

    task automatic tick(input int k = 1);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic write(input logic s, input logic st, input logic rel);
        wr_en = 1; wr_stop = s; wr_start = st; wr_release = rel;
        tick();
        wr_en = 0; wr_stop = 0; wr_start = 0; wr_release = 0;
    endtask

    task automatic wait_active(input string tag);
        for (int i = 0; i < 100 && stop_active !== 1'b1; i++) tick();
        check(stop_active === 1'b1, tag, int'(stop_active), 1);
    endtask

    task automatic wait_det(input string tag);
        for (int i = 0; i < 200 && stop_det !== 1'b1; i++) tick();
        check(stop_det === 1'b1, tag, int'(stop_det), 1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        tick(3);
        rst_n = 1;
        tick();
        // R11 reset state
        check(stop_pend === 0 && stop_active === 0 && stop_det === 0, "R11 reset flags", int'(stop_pend), 0);
        check(scl_pull === 0 && sda_pull === 0, "R11 lines released", int'(sda_pull), 0);

        // R2 not master
        master_mode = 0; write(1, 0, 0);
        check(stop_pend === 0, "R2 non-master write", int'(stop_pend), 0);
        master_mode = 1;
        // R3 stop with start
        write(1, 1, 0);
        check(stop_pend === 0, "R3 stop+start rejected", int'(stop_pend), 0);

        // R5 master receive rules
        rx_mode = 1; wait_sel = 1; wait_after9 = 0;
        write(1, 0, 0);
        check(stop_pend === 0, "R5 rx outside wait", int'(stop_pend), 0);
        eng_hold = 1; wait_now = 1; ack_en = 1;
        write(1, 0, 0);
        check(stop_pend === 0, "R5 rx with ack enabled", int'(stop_pend), 0);
        ack_en = 0;
        write(1, 0, 0);
        check(stop_pend === 1, "R5 rx final byte accepted", int'(stop_pend), 1);
        write(0, 0, 1);
        check(stop_pend === 0, "R10 release command clears", int'(stop_pend), 0);
        rx_mode = 0;

        // R1/R6 wait after 9th clock selected, wait after 8th present
        write(1, 0, 0);
        check(stop_pend === 1, "R1 stop accepted", int'(stop_pend), 1);
        tick(10);
        check(stop_active === 0, "R6 no launch at wrong wait", int'(stop_active), 0);
        wait_after9 = 1;
        wait_active("R6 launch at selected wait");
        check(sda_pull === 1 && scl_pull === 1, "R7 SDA low with SCL held", int'(scl_pull), 1);
        base = stops;
        eng_hold = 0; wait_now = 0; stretch = 1;
        tick(20);
        write(1, 0, 0);
        check(stop_pend === 1, "R4 repeated write keeps pending", int'(stop_pend), 1);
        check(sda_pull === 1 && stop_det === 0, "R7 SDA held through stretch", int'(sda_pull), 1);
        stretch = 0;
        wait_det("R9 stop detected");
        check(stops - base == 1, "R4 single stop on bus", stops - base, 1);
        check(last_run >= T_SU, "R8 SCL high before SDA rise", last_run, T_SU);
        tick();
        check(stop_pend === 0 && stop_active === 0, "R10 detected stop clears", int'(stop_pend), 0);

        // R6 wait after 8th clock selected
        wait_sel = 0; eng_hold = 1; wait_now = 1; wait_after9 = 1;
        write(1, 0, 0);
        tick(6);
        check(stop_active === 0, "R6 sel0 ignores 9th wait", int'(stop_active), 0);
        wait_after9 = 0;
        wait_active("R6 sel0 launches at 8th wait");
        base = stops;
        eng_hold = 0; wait_now = 0;
        tick(2);
        check(stop_det === 0, "R9 cleared by stop write", int'(stop_det), 0);
        wait_det("R9 second stop detected");
        check(stops - base == 1, "R6 stop produced on 9th clock high", stops - base, 1);

        // R10 arbitration loss aborts
        eng_hold = 1; wait_now = 1;
        write(1, 0, 0);
        wait_active("R10 launch before abort");
        arb_lost = 1; tick(); arb_lost = 0;
        check(stop_pend === 0, "R10 arb loss clears", int'(stop_pend), 0);
        tick();
        check(sda_pull === 0 && scl_pull === 0 && stop_active === 0, "R10 abort releases lines", int'(sda_pull), 0);
        wait_now = 0; tick(2);
        // R10 disable
        write(1, 0, 0);
        enable = 0; tick(); enable = 1;
        check(stop_pend === 0 && stop_det === 0, "R10 disable clears", int'(stop_pend), 0);
        eng_hold = 0; tick(4);

        // R9 external stop, flag cleared by start write
        ext_sda = 1; tick(4); ext_sda = 0;
        tick(4);
        check(stop_det === 1, "R9 external stop sets flag", int'(stop_det), 1);
        write(0, 1, 0);
        check(stop_det === 0, "R9 start write clears flag", int'(stop_det), 0);
        tick(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule